// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Address Filtering

This block sends and receives asynchronous serial characters over a single line in each direction. A programmable divisor drives one shared oversampling tick. The transmitter counts sixteen of these ticks per bit. The receiver uses the same ticks to find the start bit and to vote on each bit near its centre. The character length can be set from five to nine bits. Parity is optional and can be even or odd. The transmitter sends one or two stop bits.

The transmit side has one holding register in front of its shift register. An empty flag shows when the holding register can take a new character. A completion flag shows when the line has gone quiet and nothing is waiting to be sent. The receive side has one holding register. Each received character is stored with its frame-error and parity-error status, and the overrun condition is also reported. In address-filter mode the receiver drops every frame that is not marked as an address.

Top module: `uart_xcvr`

## Requirements
- R1: A tick occurs every divisor+1 clock cycles. Each transmitted bit after the start bit lasts exactly 16*(divisor+1) clock cycles.
- R2: `txd` is high when no frame is being sent. A frame sends, in order: a low start bit, the data bits LSB first, the parity bit if enabled, then one stop bit, or two when `two_stop`=1. Stop bits are high. The `char_sel` codes are 0, 1, 2 and 3 for 5, 6, 7 and 8 bits, and 7 for 9 bits. Any other code gives 8 bits. In 9-bit mode the ninth bit is `tx_bit8`, sampled on the same write strobe as `tx_data`.
- R3: Parity is present only when `par_mode[1]`=1. With `par_mode[0]`=0 the parity bit makes the count of ones over the data and parity bits even. With `par_mode[0]`=1 it makes that count odd.
- R4: `tx_empty` goes low in the cycle after an accepted write. It goes high again once the shift register has taken the character. A write while `tx_empty` is low is not accepted.
- R5: `tx_done` goes high only when the last stop bit ends and no character is waiting. A write or a `txc_clr` pulse clears it.
- R6: The receiver takes a 2-of-3 majority of samples 8, 9 and 10 of each bit. It places the data in `rx_data` and, in 9-bit mode, the ninth bit in `rx_bit8`; unused upper bits read as zero. `rx_full` stays high until an `rx_rd` pulse.
- R7: A start bit whose majority vote reads high is dropped. The receiver then waits for the next falling edge and reports nothing.
- R8: `rx_frame_err` is set when the first stop bit is received low. `rx_par_err` is set when the parity is enabled and does not match. Both belong to the stored character.
- R9: When a frame completes while `rx_full` is high, `rx_overrun` is set and the stored character is kept. `rx_rd` clears `rx_full` and `rx_overrun`.
- R10: With `mp_mode`=1, a frame is stored only if its marker is 1; otherwise no output changes. The marker is the ninth bit in 9-bit mode and the first stop bit in the other modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| divisor | input | DIV_W | Tick divisor; tick every divisor+1 clocks |
| char_sel | input | 3 | Character length code |
| par_mode | input | 2 | Bit 1 enables parity, bit 0 selects odd |
| two_stop | input | 1 | Transmit two stop bits |
| mp_mode | input | 1 | Address-filter enable |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | 8 | Low eight transmit bits |
| tx_bit8 | input | 1 | Ninth transmit bit |
| txc_clr | input | 1 | Clears `tx_done` |
| txd | output | 1 | Serial output |
| tx_empty | output | 1 | Transmit holding register empty |
| tx_done | output | 1 | Transmission complete |
| rxd | input | 1 | Serial input |
| rx_rd | input | 1 | Read strobe; empties the receive register |
| rx_data | output | 8 | Low eight received bits |
| rx_bit8 | output | 1 | Ninth received bit |
| rx_full | output | 1 | Receive register holds a character |
| rx_frame_err | output | 1 | Stop bit of stored character was low |
| rx_par_err | output | 1 | Parity mismatch in stored character |
| rx_overrun | output | 1 | A frame arrived while the register was full |

## Verification
The bench keeps the default DIV_W of 12 and runs with divisor values of 1 and 2. That gives bit times of 32 and 48 clocks, so a full 13-bit frame takes a few hundred cycles. Many randomized loopback frames fit in the run, covering every length, parity setting and stop count. Divisor 2 makes the bit period differ from the tick period, so an error in the reload count shows up directly. Frames driven by the bench itself set up the corner cases: glitched start bits, bad parity, low stop bits and unmarked frames.

// File: rtl/uart_pkg.sv
package uart_pkg;
    localparam int FRAME_W  = 13;  // start + 9 data + parity + 2 stop
    localparam int RXBITS_W = 10;  // 9 data + parity
    localparam int PH_W     = 4;   // 16 ticks per bit

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_BITS  = 2'd2
    } rx_phase_e;

    typedef struct packed {
        logic               busy;
        logic               hold;
        logic [8:0]         hold_dat;
        logic [FRAME_W-1:0] sh;
        logic [3:0]         left;
        logic [PH_W-1:0]    ph;
        logic               done;
    } tx_state_t;

    typedef struct packed {
        logic [1:0]          sync;
        logic                prev;
        rx_phase_e           st;
        logic [PH_W-1:0]     ph;
        logic [1:0]          ones;
        logic [3:0]          idx;
        logic [RXBITS_W-1:0] sh;
        logic [8:0]          dat;
        logic                full;
        logic                ferr;
        logic                perr;
        logic                ovr;
    } rx_state_t;

    function automatic logic [3:0] char_len(input logic [2:0] code);
        case (code)
            3'd0:    return 4'd5;
            3'd1:    return 4'd6;
            3'd2:    return 4'd7;
            3'd7:    return 4'd9;
            default: return 4'd8;
        endcase
    endfunction
endpackage

// File: rtl/uart_baud.sv
module uart_baud #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == '0);

    always_comb begin
        if (tick) cnt_d = divisor;
        else      cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && divisor != '0) |=> !tick); // R1
endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [2:0] char_sel,
    input  logic [1:0] par_mode,
    input  logic       two_stop,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  logic       wbit8,
    input  logic       txc_clr,
    output logic       txd,
    output logic       empty,
    output logic       done
);
    tx_state_t q, d;
    logic [3:0]         n;
    logic [3:0]         nbits;
    logic               pe;
    logic               par;
    logic [FRAME_W-1:0] frame;

    always_comb begin
        n     = char_len(char_sel);
        pe    = par_mode[1];
        par   = par_mode[0];
        for (int i = 0; i < 9; i++)
            if (i < int'(n)) par = par ^ q.hold_dat[i];
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < 9; i++)
            if (i < int'(n)) frame[i+1] = q.hold_dat[i];
        for (int i = 0; i < FRAME_W; i++)
            if (pe && i == int'(n) + 1) frame[i] = par;
        nbits = 4'd2 + n + {3'b000, pe} + {3'b000, two_stop};

        d = q;
        if (q.busy && tick) begin
            if (q.ph == 4'd15) begin
                d.ph   = '0;
                d.sh   = {1'b1, q.sh[FRAME_W-1:1]};
                d.left = q.left - 4'd1;
                if (q.left == 4'd1) begin
                    d.busy = 1'b0;
                    if (!q.hold) d.done = 1'b1;
                end
            end else begin
                d.ph = q.ph + 4'd1;
            end
        end
        if (!q.busy && q.hold) begin
            d.busy = 1'b1;
            d.hold = 1'b0;
            d.sh   = frame;
            d.left = nbits;
            d.ph   = '0;
        end
        if (wr && !q.hold) begin
            d.hold     = 1'b1;
            d.hold_dat = {wbit8, wdata};
            d.done     = 1'b0;
        end
        if (txc_clr) d.done = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.sh <= '1;
        end else begin
            q <= d;
        end
    end

    assign txd   = q.busy ? q.sh[0] : 1'b1;
    assign empty = !q.hold;
    assign done  = q.done;

    AST_DRE_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && empty) |=> !empty); // R4
    AST_TXC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!q.busy && !q.hold)); // R5
    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> !txd); // R2
endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    input  logic [2:0] char_sel,
    input  logic [1:0] par_mode,
    input  logic       mp_mode,
    input  logic       rd,
    output logic [7:0] rdata,
    output logic       rbit8,
    output logic       full,
    output logic       ferr,
    output logic       perr,
    output logic       ovr
);
    rx_state_t q, d;
    logic [3:0]      n;
    logic [3:0]      last;
    logic            pe;
    logic            line;
    logic [PH_W-1:0] ph_n;
    logic [1:0]      ones_n;
    logic            vote;
    logic            complete;
    logic            marker;
    logic            px;
    logic [8:0]      masked;

    always_comb begin
        n        = char_len(char_sel);
        pe       = par_mode[1];
        last     = n + {3'b000, pe};
        line     = q.sync[1];
        ph_n     = q.ph + 4'd1;
        ones_n   = q.ones + {1'b0, (line && ph_n >= 4'd8 && ph_n <= 4'd10)};
        vote     = (ones_n >= 2'd2);
        complete = 1'b0;

        d      = q;
        d.sync = {q.sync[0], rxd};
        d.prev = line;
        if (rd) begin
            d.full = 1'b0;
            d.ovr  = 1'b0;
        end

        case (q.st)
            RX_IDLE: begin
                d.ph   = '0;
                d.ones = '0;
                d.idx  = '0;
                if (!line && q.prev) d.st = RX_START;
            end
            default: begin
                if (tick) begin
                    d.ph   = ph_n;
                    d.ones = ones_n;
                    if (ph_n == 4'd10) begin
                        if (q.st == RX_START) begin
                            if (vote) d.st = RX_IDLE;
                        end else if (q.idx == last) begin
                            complete = 1'b1;
                            d.st     = RX_IDLE;
                        end else begin
                            for (int i = 0; i < RXBITS_W; i++)
                                if (i == int'(q.idx)) d.sh[i] = vote;
                            d.idx = q.idx + 4'd1;
                        end
                    end
                    if (ph_n == '0) begin
                        d.ones = '0;
                        if (q.st == RX_START) d.st = RX_BITS;
                    end
                end
            end
        endcase

        px = 1'b0;
        for (int i = 0; i < RXBITS_W; i++)
            if (i <= int'(n)) px = px ^ q.sh[i];
        for (int i = 0; i < 9; i++)
            masked[i] = (i < int'(n)) ? q.sh[i] : 1'b0;
        marker = (n == 4'd9) ? q.sh[8] : vote;

        if (complete && (!mp_mode || marker)) begin
            if (d.full) begin
                d.ovr = 1'b1;
            end else begin
                d.full = 1'b1;
                d.dat  = masked;
                d.ferr = !vote;
                d.perr = pe && (px != par_mode[0]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.sync <= 2'b11;
            q.prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rdata = q.dat[7:0];
    assign rbit8 = q.dat[8];
    assign full  = q.full;
    assign ferr  = q.ferr;
    assign perr  = q.perr;
    assign ovr   = q.ovr;

    AST_RXC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd) |=> full); // R6
    AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(full)); // R9
    AST_READ_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> !ovr); // R9
endmodule

// File: rtl/uart_xcvr.sv
module uart_xcvr #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    input  logic [2:0]       char_sel,
    input  logic [1:0]       par_mode,
    input  logic             two_stop,
    input  logic             mp_mode,
    input  logic             tx_wr,
    input  logic [7:0]       tx_data,
    input  logic             tx_bit8,
    input  logic             txc_clr,
    output logic             txd,
    output logic             tx_empty,
    output logic             tx_done,
    input  logic             rxd,
    input  logic             rx_rd,
    output logic [7:0]       rx_data,
    output logic             rx_bit8,
    output logic             rx_full,
    output logic             rx_frame_err,
    output logic             rx_par_err,
    output logic             rx_overrun
);
    logic tick;

    uart_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick)
    );

    uart_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .char_sel(char_sel), .par_mode(par_mode), .two_stop(two_stop),
        .wr(tx_wr), .wdata(tx_data), .wbit8(tx_bit8), .txc_clr(txc_clr),
        .txd(txd), .empty(tx_empty), .done(tx_done)
    );

    uart_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
        .char_sel(char_sel), .par_mode(par_mode), .mp_mode(mp_mode),
        .rd(rx_rd), .rdata(rx_data), .rbit8(rx_bit8), .full(rx_full),
        .ferr(rx_frame_err), .perr(rx_par_err), .ovr(rx_overrun)
    );
endmodule

// File: tb/tb_uart_xcvr.sv
module tb_uart_xcvr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] divisor = 12'd1;
    logic [2:0]  char_sel = 3'd3;
    logic [1:0]  par_mode = 2'd0;
    logic        two_stop = 1'b0;
    logic        mp_mode = 1'b0;
    logic        tx_wr = 1'b0;
    logic [7:0]  tx_data = 8'h00;
    logic        tx_bit8 = 1'b0;
    logic        txc_clr = 1'b0;
    logic        rx_rd = 1'b0;
    logic        loop_en = 1'b1;
    logic        line_drv = 1'b1;
    logic        txd, tx_empty, tx_done, rxd, rx_bit8, rx_full;
    logic        rx_frame_err, rx_par_err, rx_overrun;
    logic [7:0]  rx_data;
    int          total = 0;
    int          fails = 0;
    int          bit_clks = 32;

    always #2 clk = ~clk;
    assign rxd = loop_en ? txd : line_drv;

    uart_xcvr #(.DIV_W(12)) dut (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .char_sel(char_sel),
        .par_mode(par_mode), .two_stop(two_stop), .mp_mode(mp_mode),
        .tx_wr(tx_wr), .tx_data(tx_data), .tx_bit8(tx_bit8), .txc_clr(txc_clr),
        .txd(txd), .tx_empty(tx_empty), .tx_done(tx_done), .rxd(rxd),
        .rx_rd(rx_rd), .rx_data(rx_data), .rx_bit8(rx_bit8), .rx_full(rx_full),
        .rx_frame_err(rx_frame_err), .rx_par_err(rx_par_err), .rx_overrun(rx_overrun)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] code_of(input int n);
        return (n == 9) ? 3'd7 : 3'(n - 5);
    endfunction

    function automatic int exp_frame(input int n, input logic [8:0] d, input logic [1:0] pm,
                                     input logic two, output logic [15:0] f);
        int  k;
        logic p;
        f = '1;
        f[0] = 1'b0;
        p = pm[0];
        for (int i = 0; i < n; i++) begin
            f[1+i] = d[i];
            p = p ^ d[i];
        end
        k = 1 + n;
        if (pm[1]) begin f[k] = p; k++; end
        f[k] = 1'b1; k++;
        if (two) begin f[k] = 1'b1; k++; end
        return k;
    endfunction

    task automatic send_tx(input logic [7:0] d, input logic b8);
        @(negedge clk);
        tx_wr = 1'b1; tx_data = d; tx_bit8 = b8;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic do_read();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic wait_line(input logic v);
        for (int i = 0; i < 4000 && txd !== v; i++) @(negedge clk);
    endtask

    task automatic wait_txc();
        for (int i = 0; i < 4000 && tx_done !== 1'b1; i++) @(negedge clk);
    endtask

    task automatic capture(input int nb, output logic [15:0] got);
        got = '1;
        wait_line(1'b0);
        repeat (bit_clks / 2) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            got[i] = txd;
            if (i == 1) check("R5 tx_done low mid-frame", {31'd0, tx_done}, 32'd0);
            repeat (bit_clks) @(negedge clk);
        end
    endtask

    task automatic drive(input logic [15:0] f, input int nb);
        for (int i = 0; i < nb; i++) begin
            line_drv = f[i];
            repeat (bit_clks) @(negedge clk);
        end
        line_drv = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [15:0] f, got;
        int nb, cnt, n;
        logic [8:0] d9;
        void'($urandom(32'd20250611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check("R2 txd idle", {31'd0, txd}, 32'd1);
        check("R4 tx_empty reset", {31'd0, tx_empty}, 32'd1);
        check("R5 tx_done reset", {31'd0, tx_done}, 32'd0);
        check("R6 rx_full reset", {31'd0, rx_full}, 32'd0);

        // random loopback frames
        for (int it = 0; it < 14; it++) begin
            n = 5 + int'($urandom_range(0, 4));
            char_sel = code_of(n);
            case ($urandom_range(0, 2))
                0: par_mode = 2'b00;
                1: par_mode = 2'b10;
                default: par_mode = 2'b11;
            endcase
            two_stop = 1'($urandom_range(0, 1));
            d9 = 9'($urandom);
            nb = exp_frame(n, d9, par_mode, two_stop, f);
            send_tx(d9[7:0], d9[8]);
            capture(nb, got);
            check("R2 R3 frame bits", {16'd0, got & 16'((1 << nb) - 1)}, {16'd0, f & 16'((1 << nb) - 1)});
            wait_txc();
            check("R5 tx_done after frame", {31'd0, tx_done}, 32'd1);
            repeat (4) @(negedge clk);
            check("R6 rx_full loopback", {31'd0, rx_full}, 32'd1);
            check("R6 rx data", {23'd0, rx_bit8, rx_data},
                  {23'd0, d9 & 9'((1 << n) - 1)});
            check("R8 no errors", {30'd0, rx_frame_err, rx_par_err}, 32'd0);
            do_read();
            @(negedge clk); txc_clr = 1'b1; @(negedge clk); txc_clr = 1'b0;
            check("R5 txc_clr", {31'd0, tx_done}, 32'd0);
        end

        // R1 bit period with divisor 2
        divisor = 12'd2; bit_clks = 48;
        char_sel = 3'd3; par_mode = 2'b00; two_stop = 1'b0;
        send_tx(8'h55, 1'b0);
        wait_line(1'b0);
        wait_line(1'b1);
        cnt = 0;
        while (txd === 1'b1 && cnt < 1000) begin @(negedge clk); cnt++; end
        check("R1 bit period", cnt, 48);
        wait_txc();
        repeat (4) @(negedge clk);
        check("R1 rx at divisor 2", {24'd0, rx_data}, 32'h55);
        do_read();
        divisor = 12'd1; bit_clks = 32;

        // R4 buffering, R9 overrun
        send_tx(8'hA1, 1'b0);
        check("R4 empty low after write", {31'd0, tx_empty}, 32'd0);
        @(negedge clk);
        check("R4 empty after load", {31'd0, tx_empty}, 32'd1);
        send_tx(8'hB2, 1'b0);
        repeat (20) @(negedge clk);
        check("R4 empty low while busy", {31'd0, tx_empty}, 32'd0);
        check("R5 no done with pending", {31'd0, tx_done}, 32'd0);
        wait_txc();
        check("R4 empty at end", {31'd0, tx_empty}, 32'd1);
        repeat (4) @(negedge clk);
        check("R9 overrun set", {31'd0, rx_overrun}, 32'd1);
        check("R9 first kept", {24'd0, rx_data}, 32'hA1);
        do_read();
        check("R9 read clears", {30'd0, rx_full, rx_overrun}, 32'd0);

        // bench-driven frames
        loop_en = 1'b0;
        repeat (10) @(negedge clk);
        par_mode = 2'b10;
        nb = exp_frame(8, 9'h0C3, 2'b10, 1'b0, f);
        f[9] = ~f[9];
        drive(f, nb);
        check("R8 parity error", {30'd0, rx_par_err, rx_frame_err}, 32'd2);
        check("R8 data with parity err", {24'd0, rx_data}, 32'hC3);
        do_read();
        par_mode = 2'b00;
        nb = exp_frame(8, 9'h03C, 2'b00, 1'b0, f);
        f[9] = 1'b0;
        drive(f, nb);
        check("R8 frame error", {30'd0, rx_frame_err, rx_full}, 32'd3);
        do_read();

        // R7 false start
        line_drv = 1'b0;
        repeat (8) @(negedge clk);
        line_drv = 1'b1;
        repeat (96) @(negedge clk);
        check("R7 false start dropped", {31'd0, rx_full}, 32'd0);
        nb = exp_frame(8, 9'h0A5, 2'b00, 1'b0, f);
        drive(f, nb);
        check("R7 next frame ok", {23'd0, rx_full, rx_data}, {23'd1, 8'hA5});
        do_read();

        // R10 address filter
        mp_mode = 1'b1; char_sel = 3'd7;
        nb = exp_frame(9, 9'h033, 2'b00, 1'b0, f);
        drive(f, nb);
        check("R10 9-bit data frame dropped", {31'd0, rx_full}, 32'd0);
        nb = exp_frame(9, 9'h112, 2'b00, 1'b0, f);
        drive(f, nb);
        check("R10 9-bit address accepted", {22'd0, rx_full, rx_bit8, rx_data}, {22'd0, 2'b11, 8'h12});
        do_read();
        char_sel = 3'd3;
        nb = exp_frame(8, 9'h044, 2'b00, 1'b0, f);
        f[9] = 1'b0;
        drive(f, nb);
        check("R10 8-bit data frame dropped", {30'd0, rx_full, rx_frame_err}, 32'd0);
        nb = exp_frame(8, 9'h077, 2'b00, 1'b0, f);
        drive(f, nb);
        check("R10 8-bit address accepted", {23'd0, rx_full, rx_data}, {23'd1, 8'h77});
        do_read();
        mp_mode = 1'b0;

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule